// File: doc/BRIEF.md
# Self-Triggered Projection Readout Controller

This block is the digital back end of a binary pixel matrix that starts its own readout. Each pixel delivers a one-bit hit flag. A hit is latched only if the pixel is enabled in a serially loaded disable mask. The first latched hit raises a trigger output. The block then waits either for a programmable number of readout clocks or for an external trigger input, whichever comes first. It then freezes the latched pattern and reduces it to two projections: one bit per column (X) and one bit per row (Y). Each bit is the OR of the latched hits along that line.

The two projections leave on two serial lines in parallel, most significant line first, one bit per clock, framed by a valid strobe. One clear cycle follows, which empties every pixel latch, and the block is armed again. Masking pixels cuts hot pixels out of the data and sets the active area. No frame clock and no amplitude information are involved.

Top module: `proj_readout`

## Requirements
- R1: After reset, trig_out, frame_valid, ser_x and ser_y are low, all pixel latches are empty and every mask bit is 0 (pixel enabled).
- R2: An enabled hit sampled on a clock edge while the block is idle makes trig_out high after the next edge.
- R3: With trig_in low, trig_out stays high for exactly delay_cfg+1 cycles (delay_cfg = 0 gives one cycle). frame_valid rises in the cycle right after, and the two are never high together.
- R4: trig_in sampled high while trig_out is high ends the wait at that edge, so frame_valid is high in the following cycle.
- R5: frame_valid is high for exactly N consecutive cycles per readout.
- R6: In frame cycle i (i = 0..N-1), ser_x carries column N-1-i. That bit is the OR of the latched hits at pixel indices row*N+column over all rows. Hits are latched while idle and while waiting, so hits that arrive during the wait are included. ser_x is low outside the frame.
- R7: In frame cycle i, ser_y carries row N-1-i, the OR of the latched hits in that row. ser_y is low outside the frame.
- R8: Each idle cycle with mask_load high shifts mask_sdi into mask bit 0, and every other bit moves one index up. After N*N loads, the first bit sent sits at pixel N*N-1. A mask bit of 1 disables its pixel, so that pixel never triggers and never appears in a projection.
- R9: mask_load has no effect on the mask while the block is not idle.
- R10: Hits sampled while frame_valid is high, or in the single cycle after it, are ignored. That cycle clears all latches and the block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | N*N | Pixel hit flags, index row*N+column |
| mask_load | input | 1 | Mask shift enable (used only while idle) |
| mask_sdi | input | 1 | Mask serial data, 1 = pixel disabled |
| delay_cfg | input | DW | Wait length in readout clocks after the trigger |
| trig_in | input | 1 | External trigger, ends the wait early |
| trig_out | output | 1 | High while a triggered readout waits to start |
| frame_valid | output | 1 | High during the N serial bit cycles |
| ser_x | output | 1 | Column projection, serial |
| ser_y | output | 1 | Row projection, serial |

## Verification
A hit sampled at edge k shows on trig_out after edge k+1. frame_valid follows delay_cfg+1 trigger cycles later, or one edge after trig_in is sampled. The N data bits come in the cycles after that, and the clear cycle follows the last bit. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge from the same inputs. At the next falling edge it compares all four outputs with the model, so every result is checked in the exact cycle it is due. Directed checks count trigger and frame lengths, and they watch trig_out for several cycles after masked hits, after hits during readout and after mask loads outside idle.

// File: rtl/proj_readout.sv
module proj_readout #(
  parameter int N  = 16,
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] hit_i,
  input  logic           mask_load,
  input  logic           mask_sdi,
  input  logic [DW-1:0]  delay_cfg,
  input  logic           trig_in,
  output logic           trig_out,
  output logic           frame_valid,
  output logic           ser_x,
  output logic           ser_y
);
  localparam int NP = N * N;
  localparam int BW = $clog2(N + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT, S_CLR} st_t;

  st_t           st;
  logic [NP-1:0] lat, mask;
  logic [N-1:0]  px, py, sx, sy;
  logic [DW-1:0] dcnt;
  logic [BW-1:0] bcnt;
  logic          armed;

  assign armed       = (st == S_IDLE) || (st == S_WAIT);
  assign trig_out    = (st == S_WAIT);
  assign frame_valid = (st == S_SHIFT);
  assign ser_x       = sx[N-1];
  assign ser_y       = sy[N-1];

  always_comb begin
    px = '0;
    py = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        px[c] = px[c] | lat[r*N+c];
        py[r] = py[r] | lat[r*N+c];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            lat <= '0;
    else if (st == S_CLR)  lat <= '0;
    else if (armed)        lat <= lat | (hit_i & ~mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         mask <= '0;
    else if (st == S_IDLE && mask_load) mask <= {mask[NP-2:0], mask_sdi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      dcnt <= '0;
      bcnt <= '0;
      sx   <= '0;
      sy   <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (|lat) begin
            st   <= S_WAIT;
            dcnt <= delay_cfg;
          end
        S_WAIT:
          if (trig_in || dcnt == '0) begin
            st   <= S_SHIFT;
            sx   <= px;
            sy   <= py;
            bcnt <= '0;
          end else dcnt <= dcnt - 1'b1;
        S_SHIFT: begin
          sx   <= sx << 1;
          sy   <= sy << 1;
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(N - 1)) st <= S_CLR;
        end
        default: st <= S_IDLE;
      endcase
    end

  p_trig_fv_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_out && frame_valid));

  p_fv_after_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> $past(trig_out));

  p_clear_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid) |=> (lat == '0) && !trig_out && !frame_valid);

  p_lat_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> $stable(lat));

  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out || frame_valid) |=> $stable(mask));

  p_quiet_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> !ser_x && !ser_y);

  p_trig_from_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(lat != '0));
endmodule

// File: tb/sim_proj_readout.sv
module sim_proj_readout;
  localparam int N  = 8;
  localparam int NP = N * N;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] hit_i = '0;
  logic mask_load = 1'b0, mask_sdi = 1'b0, trig_in = 1'b0;
  logic [DW-1:0] delay_cfg = '0;
  logic trig_out, frame_valid, ser_x, ser_y;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  int m_st = 0, m_cnt = 0;
  logic [NP-1:0] m_lat = '0, m_mask = '0;
  bit qx[$], qy[$];

  proj_readout #(.N(N), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .mask_load(mask_load),
    .mask_sdi(mask_sdi), .delay_cfg(delay_cfg), .trig_in(trig_in),
    .trig_out(trig_out), .frame_valid(frame_valid), .ser_x(ser_x), .ser_y(ser_y));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=%0d expected finish before 100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    logic [NP-1:0] lat0 = m_lat, mask0 = m_mask;
    int st0 = m_st;
    case (st0)
      0: begin
        if (mask_load) m_mask = {mask0[NP-2:0], mask_sdi};
        if (lat0 != '0) begin m_st = 1; m_cnt = delay_cfg; end
      end
      1: if (trig_in || m_cnt == 0) begin
        qx.delete(); qy.delete();
        for (int i = N - 1; i >= 0; i--) begin
          bit bx = 0, by = 0;
          for (int j = 0; j < N; j++) begin
            bx |= lat0[j*N+i];
            by |= lat0[i*N+j];
          end
          qx.push_back(bx); qy.push_back(by);
        end
        m_st = 2;
      end else m_cnt--;
      2: begin
        void'(qx.pop_front()); void'(qy.pop_front());
        if (qx.size() == 0) m_st = 3;
      end
      default: begin m_lat = '0; m_st = 0; end
    endcase
    if (st0 <= 1) m_lat = lat0 | (hit_i & ~mask0);
  endtask

  task automatic compare();
    chk("R2 trig_out", trig_out, m_st == 1);
    chk("R5 frame_valid", frame_valid, m_st == 2);
    chk("R6 ser_x", ser_x, (m_st == 2) ? qx[0] : 1'b0);
    chk("R7 ser_y", ser_y, (m_st == 2) ? qy[0] : 1'b0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse(logic [NP-1:0] h);
    hit_i = h; tick(); hit_i = '0;
  endtask

  task automatic settle();
    int g = 0;
    while ((m_st != 0 || m_lat != '0) && g < 2000) begin tick(); g++; end
    tick();
  endtask

  task automatic load_mask(logic [NP-1:0] want);
    for (int k = 0; k < NP; k++) begin
      mask_sdi = want[NP-1-k]; mask_load = 1'b1; tick();
    end
    mask_load = 1'b0; mask_sdi = 1'b0;
  endtask

  task automatic quiet(string req, int n);
    for (int k = 0; k < n; k++) begin tick(); chk(req, trig_out, 1'b0); end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 trig_out", trig_out, 1'b0);
    chk("R1 frame_valid", frame_valid, 1'b0);
    chk("R1 ser_x", ser_x, 1'b0);
    chk("R1 ser_y", ser_y, 1'b0);
    quiet("R1 mask enabled, no spurious trigger", 3);

    // R3 delay length, single pixel
    delay_cfg = 8'd3;
    pulse(NP'(1) << (2*N + 5));
    chk("R2 trig low in latch cycle", trig_out, 1'b0);
    tick();
    begin
      int n = 0;
      while (trig_out && n < 300) begin n++; tick(); end
      checks++;
      if (n != 4) begin errors++; $display("FAIL R3 trig cycles act=%0d exp=%0d", n, 4); end
      chk("R3 frame after wait", frame_valid, 1'b1);
    end
    settle();

    // R3 zero delay
    delay_cfg = 8'd0;
    pulse((NP'(1) << 0) | (NP'(1) << (NP-1)));
    tick();
    chk("R3 trig high", trig_out, 1'b1);
    tick();
    chk("R3 zero delay frame", frame_valid, 1'b1);
    settle();

    // R4 external trigger, and accumulation during wait (R6)
    delay_cfg = 8'd200;
    pulse(NP'(1) << 9);
    tick(); tick();
    pulse(NP'(1) << 50);
    tick();
    trig_in = 1'b1; tick(); trig_in = 1'b0;
    chk("R4 trig_in starts frame", frame_valid, 1'b1);
    settle();

    // R10 hits during frame and clear cycle ignored
    delay_cfg = 8'd1;
    pulse(NP'(1) << 12);
    while (!frame_valid) tick();
    pulse(NP'(1) << 33);
    while (frame_valid) tick();
    pulse(NP'(1) << 44);
    quiet("R10 ignored hits", 8);

    // R8 masked pixel
    load_mask(NP'(1) << 19);
    pulse(NP'(1) << 19);
    quiet("R8 masked pixel no trigger", 6);
    pulse((NP'(1) << 19) | (NP'(1) << 60));
    settle();

    // R9 mask_load during readout ignored
    pulse(NP'(1) << 60);
    while (!frame_valid) tick();
    mask_load = 1'b1; mask_sdi = 1'b1;
    while (frame_valid) tick();
    tick();
    mask_load = 1'b0; mask_sdi = 1'b0;
    settle();
    pulse(NP'(1) << 0);
    tick();
    chk("R9 pixel still enabled", trig_out, 1'b1);
    settle();
    load_mask('0);

    // random patterns
    for (int it = 0; it < 25; it++) begin
      logic [NP-1:0] h;
      delay_cfg = DW'($urandom % 6);
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if (h == '0) h[it] = 1'b1;
      pulse(h);
      pulse({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      settle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule